// File: doc/BRIEF.md
# Packed Integer Vector ALU with Per-Lane Predication

This block performs one packed integer operation on two 256-bit operand vectors per accepted input. The vector is cut into lanes of 8, 16, 32 or 64 bits, chosen with each operation. Lane 0 sits in the least significant bits. A single byte-sliced adder serves every lane width. The carry into each byte comes either from the byte below it or, at a lane boundary, from the operation's own carry-in. This keeps every lane independent of its neighbours.

The operations are wrapping add and subtract, signed and unsigned saturating add and subtract, equality and signed greater-than compare, and three bitwise functions. A per-lane predicate mask chooses which lanes take the computed value. Lanes whose mask bit is clear take either the matching lane of a previous-value vector (merge) or zero (zeroing).

The result and a valid flag are registered one cycle after an input is accepted. The result holds while no input is presented.

Top module: `simd_lane_alu`

## Requirements
- R1: `lane_sel` encodes the lane width as 0=8, 1=16, 2=32 and 3=64 bits. Lane i occupies bits [i*w +: w], and no carry or result ever crosses a lane boundary.
- R2: Opcode 0 adds and opcode 1 subtracts (a-b). Both wrap modulo 2^w in every lane.
- R3: For 8-bit and 16-bit lanes, opcodes 2 (signed add), 3 (unsigned add), 4 (signed sub) and 5 (unsigned sub) clamp to the representable range: signed to [-2^(w-1), 2^(w-1)-1], unsigned to [0, 2^w-1].
- R4: For 32-bit and 64-bit lanes, opcodes 2 and 4 act as plain wrapping add and subtract, and opcodes 3 and 5 do the same. The saturation is ignored.
- R5: Opcode 6 (equal) and opcode 7 (signed a > b) write all ones into a lane when the test is true and all zeros when it is false.
- R6: Opcode 8 gives a&b, opcode 9 gives (~a)&b and opcode 10 gives a|b.
- R7: Bit i of `lane_mask` predicates lane i. Mask bits at or above the current lane count (256/w) have no effect.
- R8: With `zero_mode`=0, a lane whose mask bit is 0 outputs the same lane of `prev_val`.
- R9: With `zero_mode`=1, a lane whose mask bit is 0 outputs zero.
- R10: With `in_valid` high at a clock edge, `res_valid` and `res_data` reflect that input after the edge. With `in_valid` low, `res_valid` is 0 after the edge and `res_data` keeps its value.
- R11: While `rst_n` is low, `res_valid` and `res_data` are 0.
- R12: Opcodes 11 to 15 give a zero value in each lane, before predication is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the operation presented this cycle |
| op_code | input | 4 | Operation select |
| lane_sel | input | 2 | Lane width select |
| zero_mode | input | 1 | 1 = zeroing predication, 0 = merge predication |
| src_a | input | 256 | First operand vector |
| src_b | input | 256 | Second operand vector |
| prev_val | input | 256 | Value kept by masked-off lanes in merge mode |
| lane_mask | input | 32 | One predicate bit per lane |
| res_valid | output | 1 | Result register holds a new result |
| res_data | output | 256 | Registered result vector |

## Verification
A stimulus table drives each opcode at several lane widths, and a lane-by-lane arithmetic model in the bench gives the expected result. The operands mix values that carry out of a byte, sit at the signed limits and cross 32-bit halves. These separate a chain cut at the right boundary from one cut in the wrong place, and saturating from wrapping behaviour. Alternating mask patterns in both predication modes show whether a masked lane takes the previous value, takes zero, or leaks the computed value. Directed cases use literal results to pin down the saturation limits, saturation being ignored on wide lanes, mask bits above the lane count, unknown opcodes and the hold behaviour of the result register.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_ADDSS = 4'd2,
      OP_ADDUS = 4'd3,
      OP_SUBSS = 4'd4,
      OP_SUBUS = 4'd5,
      OP_CMPEQ = 4'd6,
      OP_CMPGT = 4'd7,
      OP_AND   = 4'd8,
      OP_ANDN  = 4'd9,
      OP_OR    = 4'd10
   } op_e;

   // lane width select: bytes per lane = 1 << sel
   function automatic int lane_bytes(input logic [1:0] sel);
      return 1 << sel;
   endfunction

   function automatic logic uses_sub(input op_e op);
      return (op == OP_SUB) || (op == OP_SUBSS) || (op == OP_SUBUS) ||
             (op == OP_CMPGT);
   endfunction

endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder
   import simd_alu_pkg::*;
#(
   parameter int NB = 32
) (
   input  logic [NB*8-1:0] a,
   input  logic [NB*8-1:0] b,
   input  logic            sub,
   input  logic [1:0]      wsel,
   output logic [NB*8-1:0] sum,
   output logic [NB-1:0]   cout,
   output logic [NB-1:0]   ovf
);

   always_comb begin
      logic c;
      c = 1'b0;
      sum = '0;
      cout = '0;
      ovf = '0;
      for (int j = 0; j < NB; j++) begin
         int       lb;
         logic     ci;
         logic [7:0] av;
         logic [7:0] bx;
         logic [8:0] s;
         lb = lane_bytes(wsel);
         // carry chain is cut at every lane start
         ci = ((j % lb) == 0) ? sub : c;
         av = a[j*8 +: 8];
         bx = sub ? ~b[j*8 +: 8] : b[j*8 +: 8];
         s  = {1'b0, av} + {1'b0, bx} + {8'd0, ci};
         sum[j*8 +: 8] = s[7:0];
         cout[j] = s[8];
         ovf[j]  = (av[7] == bx[7]) && (s[7] != av[7]);
         c = s[8];
      end
   end

endmodule

// File: rtl/simd_lane_post.sv
module simd_lane_post
   import simd_alu_pkg::*;
#(
   parameter int NB = 32
) (
   input  op_e             op,
   input  logic [1:0]      wsel,
   input  logic [NB*8-1:0] a,
   input  logic [NB*8-1:0] b,
   input  logic [NB*8-1:0] sum,
   input  logic [NB-1:0]   cout,
   input  logic [NB-1:0]   ovf,
   output logic [NB*8-1:0] raw
);

   logic [NB-1:0] beq;

   genvar gj;
   generate
      for (gj = 0; gj < NB; gj++) begin : g_beq
         assign beq[gj] = (a[gj*8 +: 8] == b[gj*8 +: 8]);
      end
   endgenerate

   always_comb begin
      raw = '0;
      for (int j = 0; j < NB; j++) begin
         int         lb;
         int         base;
         int         t;
         logic       leq;
         logic       lovf;
         logic       lc;
         logic       asg;
         logic       lt;
         logic       narrow;
         logic [7:0] sb;
         logic [7:0] ab;
         logic [7:0] bb;
         logic [7:0] ssat;
         logic [7:0] rb;
         lb   = lane_bytes(wsel);
         base = j - (j % lb);
         t    = base + lb - 1;
         leq  = 1'b1;
         for (int k = 0; k < 8; k++)
            if (k < lb) leq = leq & beq[(base + k) % NB];
         lovf   = ovf[t];
         lc     = cout[t];
         asg    = a[t*8 + 7];
         lt     = sum[t*8 + 7] ^ lovf;
         narrow = (wsel < 2'd2);
         sb     = sum[j*8 +: 8];
         ab     = a[j*8 +: 8];
         bb     = b[j*8 +: 8];
         // signed limit: top byte carries the sign
         if (j == t) ssat = asg ? 8'h80 : 8'h7F;
         else        ssat = asg ? 8'h00 : 8'hFF;
         case (op)
            OP_ADD, OP_SUB:     rb = sb;
            OP_ADDSS, OP_SUBSS: rb = (narrow && lovf) ? ssat : sb;
            OP_ADDUS:           rb = (narrow && lc) ? 8'hFF : sb;
            OP_SUBUS:           rb = (narrow && !lc) ? 8'h00 : sb;
            OP_CMPEQ:           rb = leq ? 8'hFF : 8'h00;
            OP_CMPGT:           rb = (!lt && !leq) ? 8'hFF : 8'h00;
            OP_AND:             rb = ab & bb;
            OP_ANDN:            rb = ~ab & bb;
            OP_OR:              rb = ab | bb;
            default:            rb = 8'h00;
         endcase
         raw[j*8 +: 8] = rb;
      end
   end

endmodule

// File: rtl/simd_mask_write.sv
module simd_mask_write #(
   parameter int NB = 32
) (
   input  logic [NB*8-1:0] raw,
   input  logic [NB*8-1:0] prev,
   input  logic [NB-1:0]   mask,
   input  logic [1:0]      wsel,
   input  logic            zero_mode,
   output logic [NB*8-1:0] out
);

   genvar gj;
   generate
      for (gj = 0; gj < NB; gj++) begin : g_byte
         logic en;
         assign en = mask[gj >> wsel];
         assign out[gj*8 +: 8] = en ? raw[gj*8 +: 8] :
                                 (zero_mode ? 8'h00 : prev[gj*8 +: 8]);
      end
   endgenerate

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
   import simd_alu_pkg::*;
#(
   parameter int VEC_W = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [3:0]         op_code,
   input  logic [1:0]         lane_sel,
   input  logic               zero_mode,
   input  logic [VEC_W-1:0]   src_a,
   input  logic [VEC_W-1:0]   src_b,
   input  logic [VEC_W-1:0]   prev_val,
   input  logic [VEC_W/8-1:0] lane_mask,
   output logic               res_valid,
   output logic [VEC_W-1:0]   res_data
);

   localparam int NB = VEC_W / 8;

   initial begin
      vec_width_chk: assert (VEC_W >= 64 && (VEC_W % 64) == 0)
         else $error("VEC_W must be a positive multiple of 64");
   end

   op_e              op_t;
   logic             sub_m;
   logic [VEC_W-1:0] sum_w;
   logic [NB-1:0]    cout_w;
   logic [NB-1:0]    ovf_w;
   logic [VEC_W-1:0] raw_w;
   logic [VEC_W-1:0] next_w;

   assign op_t  = op_e'(op_code);
   assign sub_m = uses_sub(op_t);

   simd_seg_adder #(.NB(NB)) u_add (
      .a(src_a), .b(src_b), .sub(sub_m), .wsel(lane_sel),
      .sum(sum_w), .cout(cout_w), .ovf(ovf_w)
   );

   simd_lane_post #(.NB(NB)) u_post (
      .op(op_t), .wsel(lane_sel), .a(src_a), .b(src_b),
      .sum(sum_w), .cout(cout_w), .ovf(ovf_w), .raw(raw_w)
   );

   simd_mask_write #(.NB(NB)) u_mask (
      .raw(raw_w), .prev(prev_val), .mask(lane_mask), .wsel(lane_sel),
      .zero_mode(zero_mode), .out(next_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
      end else begin
         res_valid <= in_valid;
         if (in_valid) res_data <= next_w;
      end
   end

   // R10
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);
   // R10
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid);
   // R10
   hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(res_data));
   // R9
   zero_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && zero_mode && !lane_mask[0]) |=> (res_data[7:0] == 8'h00));
   // R8
   merge_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !zero_mode && !lane_mask[0]) |=>
      (res_data[7:0] == $past(prev_val[7:0])));
   // R5
   cmp_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_mask[0] && (op_code == 4'd6 || op_code == 4'd7)) |=>
      (res_data[7:0] == 8'h00 || res_data[7:0] == 8'hFF));

endmodule

// File: tb/simd_lane_alu_bench.sv
module simd_lane_alu_bench;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   op_code = '0;
   logic [1:0]   lane_sel = '0;
   logic         zero_mode = 1'b0;
   logic [255:0] src_a = '0, src_b = '0, prev_val = '0;
   logic [31:0]  lane_mask = '0;
   logic         res_valid;
   logic [255:0] res_data;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   simd_lane_alu u_simd_lane_alu (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
      .lane_sel(lane_sel), .zero_mode(zero_mode), .src_a(src_a),
      .src_b(src_b), .prev_val(prev_val), .lane_mask(lane_mask),
      .res_valid(res_valid), .res_data(res_data)
   );

   typedef struct packed {
      logic [3:0]   op;
      logic [1:0]   w;
      logic         zm;
      logic [255:0] a;
      logic [255:0] b;
      logic [255:0] p;
      logic [31:0]  m;
      logic [3:0]   rq;
   } vec_t;

   localparam int NROWS = 14;
   localparam logic [255:0] PV = {4{64'hDEAD_BEEF_0123_4567}};
   localparam vec_t TBL [NROWS] = '{
      '{4'd0, 2'd0, 1'b0, {8{32'h80FF_7F01}}, {8{32'h0101_0180}}, PV, 32'hA5A5_5A5A, 4'd2},  // R2 R8
      '{4'd1, 2'd1, 1'b1, {8{32'h0000_8000}}, {8{32'h0001_0001}}, PV, 32'h0000_F0F3, 4'd2},  // R2 R9
      '{4'd2, 2'd1, 1'b0, {8{32'h7FF0_8010}}, {8{32'h0020_FFE0}}, PV, 32'hFFFF_FFFF, 4'd3},  // R3
      '{4'd4, 2'd0, 1'b1, {8{32'h807F_0010}}, {8{32'h01FF_7F20}}, PV, 32'hFFFF_FFFF, 4'd3},  // R3
      '{4'd3, 2'd1, 1'b0, {8{32'hFFF0_1234}}, {8{32'h0020_0001}}, PV, 32'h0000_FFFF, 4'd3},  // R3
      '{4'd5, 2'd0, 1'b0, {8{32'h1020_FF00}}, {8{32'h2010_0101}}, PV, 32'hFFFF_FFFF, 4'd3},  // R3
      '{4'd6, 2'd2, 1'b0, {4{64'h1234_5678_0000_0001}}, {4{64'h1234_5678_0000_0002}}, PV, 32'h0000_00FF, 4'd5},  // R5
      '{4'd7, 2'd3, 1'b0, {2{128'h8000_0000_0000_0000_7000_0000_0000_0000}},
                          {2{128'h0000_0000_0000_0001_6FFF_FFFF_FFFF_FFFF}}, PV, 32'h0000_000F, 4'd5},  // R5
      '{4'd7, 2'd0, 1'b1, {8{32'h7F80_0505}}, {8{32'h8081_0506}}, PV, 32'hFFFF_FFFF, 4'd5},  // R5
      '{4'd9, 2'd2, 1'b0, {8{32'hF0F0_00FF}}, {8{32'hFFFF_0F0F}}, PV, 32'h0000_0055, 4'd6},  // R6 R8
      '{4'd10, 2'd3, 1'b1, {8{32'h0F00_00F0}}, {8{32'h0000_0F0F}}, PV, 32'h0000_0005, 4'd6},  // R6 R9
      '{4'd8, 2'd1, 1'b0, {8{32'hAAAA_5555}}, {8{32'hFF00_0FF0}}, PV, 32'h0000_FFFF, 4'd6},  // R6
      '{4'd0, 2'd3, 1'b0, {4{64'h0000_0000_FFFF_FFFF}}, {4{64'h0000_0000_0000_0001}}, PV, 32'h0000_000F, 4'd1},  // R1
      '{4'd4, 2'd3, 1'b0, {4{64'h8000_0000_0000_0000}}, {4{64'h0000_0000_0000_0001}}, PV, 32'h0000_000F, 4'd4}   // R4
   };

   function automatic logic [255:0] model(input logic [3:0] op, input logic [1:0] w,
         input logic zm, input logic [255:0] a, input logic [255:0] b,
         input logic [255:0] p, input logic [31:0] m);
      logic [255:0] out;
      int lw;
      int n;
      logic [63:0] mk;
      logic [63:0] half;
      out = '0;
      lw = 8 << w;
      n = 256 / lw;
      mk = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
      half = 64'd1 << (lw - 1);
      for (int i = 0; i < n; i++) begin
         logic [63:0] av, bv, pv, r;
         longint sa, sb, s, smax, smin, umax;
         av = 64'(a >> (i*lw)) & mk;
         bv = 64'(b >> (i*lw)) & mk;
         pv = 64'(p >> (i*lw)) & mk;
         sa = $signed((av ^ half) - half);
         sb = $signed((bv ^ half) - half);
         smax = $signed(half - 64'd1);
         smin = -smax - 1;
         umax = $signed(mk);
         case (op)
            4'd0: r = av + bv;
            4'd1: r = av - bv;
            4'd2, 4'd4: begin
               if (lw <= 16) begin
                  s = (op == 4'd2) ? sa + sb : sa - sb;
                  if (s > smax) s = smax;
                  if (s < smin) s = smin;
                  r = s;
               end else r = (op == 4'd2) ? av + bv : av - bv;
            end
            4'd3, 4'd5: begin
               if (lw <= 16) begin
                  s = (op == 4'd3) ? longint'(av) + longint'(bv) : longint'(av) - longint'(bv);
                  if (s > umax) s = umax;
                  if (s < 0) s = 0;
                  r = s;
               end else r = (op == 4'd3) ? av + bv : av - bv;
            end
            4'd6: r = (av == bv) ? mk : 64'd0;
            4'd7: r = (sa > sb) ? mk : 64'd0;
            4'd8: r = av & bv;
            4'd9: r = ~av & bv;
            4'd10: r = av | bv;
            default: r = 64'd0;
         endcase
         r = r & mk;
         if (!m[i]) r = zm ? 64'd0 : pv;
         out = out | (256'(r) << (i*lw));
      end
      return out;
   endfunction

   task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [1:0] w, input logic zm,
         input logic [255:0] a, input logic [255:0] b, input logic [255:0] p,
         input logic [31:0] m);
      @(negedge clk);
      op_code = op; lane_sel = w; zero_mode = zm;
      src_a = a; src_b = b; prev_val = p; lane_mask = m;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [255:0] held;
      repeat (3) @(negedge clk);
      // R11
      check("R11 valid", {255'd0, res_valid}, 256'd0);
      check("R11 data", res_data, 256'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NROWS; i++) begin
         apply(TBL[i].op, TBL[i].w, TBL[i].zm, TBL[i].a, TBL[i].b, TBL[i].p, TBL[i].m);
         check($sformatf("R%0d row %0d", TBL[i].rq, i), res_data,
               model(TBL[i].op, TBL[i].w, TBL[i].zm, TBL[i].a, TBL[i].b, TBL[i].p, TBL[i].m));
         check("R10 valid set", {255'd0, res_valid}, 256'd1);
      end

      // R1: no carry crosses 8-bit lanes
      apply(4'd0, 2'd0, 1'b0, {32{8'hFF}}, {32{8'h01}}, PV, 32'hFFFF_FFFF);
      check("R1 byte carry cut", res_data, 256'd0);
      // R1: carry stays inside 16-bit lanes
      apply(4'd0, 2'd1, 1'b0, {16{16'h00FF}}, {16{16'h0001}}, PV, 32'hFFFF_FFFF);
      check("R1 halfword carry", res_data, {16{16'h0100}});
      // R3: signed clamp at +max
      apply(4'd2, 2'd0, 1'b0, {32{8'h7F}}, {32{8'h01}}, PV, 32'hFFFF_FFFF);
      check("R3 signed max", res_data, {32{8'h7F}});
      // R3: unsigned add clamp
      apply(4'd3, 2'd0, 1'b0, {32{8'hFF}}, {32{8'h01}}, PV, 32'hFFFF_FFFF);
      check("R3 unsigned max", res_data, {32{8'hFF}});
      // R3: unsigned sub floor
      apply(4'd5, 2'd1, 1'b0, {16{16'h0010}}, {16{16'h0020}}, PV, 32'hFFFF_FFFF);
      check("R3 unsigned floor", res_data, 256'd0);
      // R4: unsigned saturating add wraps at 32 bits
      apply(4'd3, 2'd2, 1'b0, {8{32'hFFFF_FFFF}}, {8{32'h0000_0001}}, PV, 32'hFFFF_FFFF);
      check("R4 wide wrap", res_data, 256'd0);
      // R7: mask bits above four 64-bit lanes ignored
      apply(4'd8, 2'd3, 1'b1, {256{1'b1}}, {256{1'b1}}, PV, 32'hFFFF_FFF0);
      check("R7 upper mask ignored", res_data, 256'd0);
      apply(4'd8, 2'd3, 1'b1, {256{1'b1}}, {256{1'b1}}, PV, 32'h0000_000F);
      check("R7 lower mask used", res_data, {256{1'b1}});
      // R12: undefined opcode gives zero lanes
      apply(4'd12, 2'd0, 1'b0, {256{1'b1}}, {256{1'b1}}, PV, 32'hFFFF_FFFF);
      check("R12 undefined op", res_data, 256'd0);
      // R8: merge with all lanes off returns previous value
      apply(4'd0, 2'd2, 1'b0, {256{1'b1}}, {256{1'b1}}, PV, 32'h0);
      check("R8 all merged", res_data, PV);
      held = res_data;
      // R10: idle cycle drops valid, holds data
      src_a = '0;
      @(negedge clk);
      check("R10 valid drop", {255'd0, res_valid}, 256'd0);
      check("R10 data hold", res_data, held);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule